// File: doc/BRIEF.md
# Four-Bit Bidirectional GPIO Port with Pullups

This block is a small memory-mapped general-purpose I/O port for a simple CPU register bus. Software reaches three registers through an address, a write strobe, write data and combinational read data. The data register holds the value each pin drives. The direction register decides whether each pin drives or listens. The pullup register picks which listening pins get a weak pull to the supply.

For each of its four pins the port gives an external pad model three signals: the value to drive, an output enable and a pullup enable. Pin levels come back through a two-flop synchronizer. A read of the data register is steered bit by bit. An output pin returns its latch value and an input pin returns its synchronized level. The latch can be written at any time. A value written to an input pin's latch is kept and appears once that pin becomes an output. The pullup of a pin is cut off whenever that pin drives, whatever its enable bit says.

Register access completes in one cycle and the bus has no back-pressure: every strobe is accepted on the clock edge where it is high. The pin signals are plain level signals with no handshake.

Top module: `gpio_quad_port`

## Requirements
- R1: While reset is asserted and right after it, the data latch, direction and pullup registers are all zero: pin_out, pin_oe and pin_pu are 4'h0, and reads of offsets 0x04 and 0x0D return 8'h00.
- R2: A read of offset 0x00 returns, in bit i (i = 0..3), the latch bit when direction bit i is 1 and the synchronized level of pin i when it is 0. Bits 7:4 read 0.
- R3: A write to offset 0x00 loads bus_wdata[3:0] into all four latch bits whatever the direction bits are. A latch bit of an input pin is not visible on read-back until that pin's direction bit becomes 1.
- R4: pin_out equals the latch and pin_oe equals the direction register, bit for bit. A pullup enable bit has no effect on a driving pin.
- R5: pin_pu[i] is pullup bit i AND NOT direction bit i. It never rises on a pin whose pin_oe is 1, and it comes back as soon as that pin returns to input.
- R6: Offset 0x0D holds the pullup enables in bits 3:0. They can be read and written. Bits 7:4 ignore writes and read 0.
- R7: Offset 0x04 holds the direction bits in bits 3:0 (1 = output, 0 = input). They can be read and written, and bits 7:4 read 0. A write shows on pin_oe from the next clock.
- R8: A change on an input pin appears on a read of offset 0x00 two rising clock edges after it is applied, and not before.
- R9: A read of any offset other than 0x00, 0x04 and 0x0D returns 8'h00, and a write to such an offset changes no register.
- R10: A register changes only on a rising clock edge with bus_wr high. Presenting an address and data with bus_wr low changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register offset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| pin_in | input | 4 | Levels seen at the pads |
| pin_out | output | 4 | Value driven onto each pad |
| pin_oe | output | 4 | Output enable per pad |
| pin_pu | output | 4 | Pullup enable per pad |

## Verification
The assertions check on every cycle that a data write reaches pin_out and a direction write reaches pin_oe on the next edge. They also check that no pad is pulled up while it drives, and that unmapped offsets and the upper bits of the pullup register read zero. Only the bench scenarios can show the per-bit read steering against a modelled pad, the two-edge delay of a pin change, and that a latch value written to an input pin stays hidden until the pin turns to output. The same goes for writes with the strobe low or to unmapped offsets leaving every register alone.

// File: rtl/gpio_quad_pkg.sv
package gpio_quad_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_DATA = 2'd1,
    SEL_DIR  = 2'd2,
    SEL_PULL = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
  import gpio_quad_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_OFS = 'h00,
  parameter int DIR_OFS  = 'h04,
  parameter int PULL_OFS = 'h0D
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);
  always_comb begin
    if (addr == ADDR_W'(DATA_OFS))      sel = SEL_DATA;
    else if (addr == ADDR_W'(DIR_OFS))  sel = SEL_DIR;
    else if (addr == ADDR_W'(PULL_OFS)) sel = SEL_PULL;
    else                                sel = SEL_NONE;
  end
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= din;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= stage_q[s-1];
      end
    end
  endgenerate

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_pin_ctrl.sv
module gpio_pin_ctrl #(
  parameter int W = 4
) (
  input  logic [W-1:0] latch_q,
  input  logic [W-1:0] dir_q,
  input  logic [W-1:0] pull_q,
  input  logic [W-1:0] pin_sync,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe,
  output logic [W-1:0] pin_pu,
  output logic [W-1:0] data_rd
);
  generate
    for (genvar i = 0; i < W; i++) begin : g_bit
      assign pin_out[i] = latch_q[i];
      assign pin_oe[i]  = dir_q[i];
      assign pin_pu[i]  = pull_q[i] & ~dir_q[i];
      assign data_rd[i] = dir_q[i] ? latch_q[i] : pin_sync[i];
    end
  endgenerate
endmodule

// File: rtl/gpio_quad_port.sv
module gpio_quad_port
  import gpio_quad_pkg::*;
#(
  parameter int WIDTH       = 4,
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int DATA_OFS    = 'h00,
  parameter int DIR_OFS     = 'h04,
  parameter int PULL_OFS    = 'h0D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [WIDTH-1:0]  pin_in,
  output logic [WIDTH-1:0]  pin_out,
  output logic [WIDTH-1:0]  pin_oe,
  output logic [WIDTH-1:0]  pin_pu
);
  localparam int PAD_W = DATA_W - WIDTH;

  reg_sel_e         sel;
  logic [WIDTH-1:0] latch_q, dir_q, pull_q;
  logic [WIDTH-1:0] pin_sync, data_rd;
  logic             unused_wdata_hi;

  assign unused_wdata_hi = ^bus_wdata[DATA_W-1:WIDTH];

  gpio_addr_decode #(
    .ADDR_W(ADDR_W), .DATA_OFS(DATA_OFS), .DIR_OFS(DIR_OFS), .PULL_OFS(PULL_OFS)
  ) u_dec (
    .addr(bus_addr),
    .sel (sel)
  );

  gpio_sync #(.W(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (pin_in),
    .dout (pin_sync)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
      dir_q   <= '0;
      pull_q  <= '0;
    end else if (bus_wr) begin
      case (sel)
        SEL_DATA: latch_q <= bus_wdata[WIDTH-1:0];
        SEL_DIR:  dir_q   <= bus_wdata[WIDTH-1:0];
        SEL_PULL: pull_q  <= bus_wdata[WIDTH-1:0];
        default:  ;
      endcase
    end
  end

  gpio_pin_ctrl #(.W(WIDTH)) u_pins (
    .latch_q (latch_q),
    .dir_q   (dir_q),
    .pull_q  (pull_q),
    .pin_sync(pin_sync),
    .pin_out (pin_out),
    .pin_oe  (pin_oe),
    .pin_pu  (pin_pu),
    .data_rd (data_rd)
  );

  always_comb begin
    case (sel)
      SEL_DATA: bus_rdata = {{PAD_W{1'b0}}, data_rd};
      SEL_DIR:  bus_rdata = {{PAD_W{1'b0}}, dir_q};
      SEL_PULL: bus_rdata = {{PAD_W{1'b0}}, pull_q};
      default:  bus_rdata = '0;
    endcase
  end

  // R3
  latch_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(DATA_OFS)) |=> (pin_out == $past(bus_wdata[WIDTH-1:0])));

  // R7
  dir_to_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(DIR_OFS)) |=> (pin_oe == $past(bus_wdata[WIDTH-1:0])));

  // R5
  no_pull_on_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_pu & pin_oe) == '0));

  // R9
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr != ADDR_W'(DATA_OFS) && bus_addr != ADDR_W'(DIR_OFS) &&
     bus_addr != ADDR_W'(PULL_OFS)) |-> (bus_rdata == '0));

  // R6
  pull_hi_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(PULL_OFS)) |-> (bus_rdata[DATA_W-1:WIDTH] == '0));
endmodule

// File: tb/tb_gpio_quad_port.sv
`timescale 1ns/1ps
module tb_gpio_quad_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus_addr = 8'h00;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic [3:0] pin_in, pin_out, pin_oe, pin_pu;

  logic [3:0] ext_en = 4'h0, ext_val = 4'h0;
  logic [3:0] m_lat = 4'h0, m_dir = 4'h0, m_pull = 4'h0;
  logic [3:0] hist1, hist2;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  gpio_quad_port dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .pin_pu(pin_pu)
  );

  // pad model: driver wins, then external source, then pullup, else reads low
  assign pin_in = (pin_oe & pin_out) | (~pin_oe & ext_en & ext_val) |
                  (~pin_oe & ~ext_en & pin_pu);

  // pin level as seen two edges earlier (R8)
  always @(posedge clk or negedge rst_n)
    if (!rst_n) begin hist1 <= 4'h0; hist2 <= 4'h0; end
    else begin hist1 <= pin_in; hist2 <= hist1; end

  function automatic logic [7:0] exp_read(logic [7:0] a);
    case (a)
      8'h00:   return {4'h0, (m_dir & m_lat) | (~m_dir & hist2)};
      8'h04:   return {4'h0, m_dir};
      8'h0D:   return {4'h0, m_pull};
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    case (a)
      8'h00: m_lat = d[3:0];
      8'h04: m_dir = d[3:0];
      8'h0D: m_pull = d[3:0];
      default: ;
    endcase
  endtask

  task automatic rd_chk(string req, logic [7:0] a);
    bus_addr = a; #1;
    check(req, bus_rdata, exp_read(a));
  endtask

  task automatic pins_chk();
    check("R4 pin_out", {4'h0, pin_out}, {4'h0, m_lat});
    check("R4 pin_oe", {4'h0, pin_oe}, {4'h0, m_dir});
    check("R5 pin_pu", {4'h0, pin_pu}, {4'h0, m_pull & ~m_dir});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED_0A4C));
    repeat (3) @(negedge clk);
    // R1 reset state
    pins_chk();
    rd_chk("R1 dir reset", 8'h04);
    rd_chk("R1 pull reset", 8'h0D);
    rd_chk("R1 data reset", 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    rd_chk("R1 dir after reset", 8'h04);

    // R6 upper bits of pullup register ignored
    wr(8'h0D, 8'hFF);
    rd_chk("R6 pull reads 0F", 8'h0D);
    pins_chk();
    // R7 direction and R5 pullup gating
    wr(8'h04, 8'hF5);
    rd_chk("R7 dir reads 05", 8'h04);
    check("R5 pull gated", {4'h0, pin_pu}, 8'h0A);
    wr(8'h04, 8'h00);
    check("R5 pull returns", {4'h0, pin_pu}, 8'h0F);

    // R3 latch hidden while input, visible once output
    ext_en = 4'hF; ext_val = 4'h0;
    wr(8'h00, 8'h0F);
    repeat (3) @(negedge clk);
    check("R3 latch hidden", bus_rdata, 8'h00);
    check("R3 pin_out holds latch", {4'h0, pin_out}, 8'h0F);
    wr(8'h04, 8'h0F);
    rd_chk("R3 latch visible", 8'h00);
    check("R3 latch visible value", bus_rdata, 8'h0F);

    // R8 two-edge latency
    wr(8'h04, 8'h00);
    ext_val = 4'h9;
    repeat (3) @(negedge clk);
    bus_addr = 8'h00;
    ext_val = 4'h6;
    @(negedge clk); #1;
    check("R8 not yet after one edge", bus_rdata, 8'h09);
    @(negedge clk); #1;
    check("R8 visible after two edges", bus_rdata, 8'h06);

    // R2 mixed steering
    wr(8'h00, 8'h05);
    wr(8'h04, 8'h03);
    repeat (2) @(negedge clk);
    rd_chk("R2 mixed steering", 8'h00);
    check("R2 mixed value", bus_rdata, 8'h05);

    // R10 strobe low changes nothing
    @(negedge clk);
    bus_addr = 8'h04; bus_wdata = 8'hFC; bus_wr = 1'b0;
    @(negedge clk);
    rd_chk("R10 no write without strobe", 8'h04);

    // R9 unmapped offsets
    wr(8'h05, 8'hFF);
    wr(8'h0C, 8'hFF);
    rd_chk("R9 unmapped read", 8'h05);
    rd_chk("R9 unmapped read", 8'hFF);
    rd_chk("R9 dir untouched", 8'h04);
    rd_chk("R9 pull untouched", 8'h0D);

    // random mix
    for (int i = 0; i < 600; i++) begin
      int op;
      op = $urandom % 5;
      if (op == 0) begin
        logic [7:0] a;
        case ($urandom % 4)
          0: a = 8'h00;
          1: a = 8'h04;
          2: a = 8'h0D;
          default: a = 8'($urandom);
        endcase
        wr(a, 8'($urandom));
      end else if (op == 1) begin
        @(negedge clk);
        ext_en = 4'($urandom); ext_val = 4'($urandom);
      end else begin
        @(negedge clk);
        case ($urandom % 4)
          0: rd_chk("R2 random read", 8'h00);
          1: rd_chk("R7 random read", 8'h04);
          2: rd_chk("R6 random read", 8'h0D);
          default: rd_chk("R9 random read", 8'($urandom));
        endcase
        pins_chk();
      end
    end
    finish_run();
  end
endmodule